// File: doc/BRIEF.md
# Tilemap Scroll Address Generator

This block produces the scan addresses for one scrolling tile layer of a raster display. Two loadable up/down counters track the horizontal and the vertical scan position inside a 512 x 512 pixel playfield built from 8 x 8 tiles arranged 64 x 64. The upper bits of both counters form the tilemap RAM address. The tile code that the RAM returns is joined with the three fine row bits of the vertical counter to form the graphics ROM address.

A CPU sets the layer's scroll offsets through a write strobe, a two-bit target select and a data bus. Its writes land in shadow registers that may change at any moment of the frame. The scan counters take the new values only on the next rising edge of vertical sync, so a scroll change never tears a picture that is being drawn. The CPU can also write a tilemap address of its own and, through a mode input, take over the tilemap RAM address outputs to store new tile entries. A flip input makes both counters count down, which mirrors the layer. The horizontal and vertical sync inputs are treated as asynchronous levels. They pass through a synchronizer and an edge detector, and everything runs on the one system clock.

Top module: `tsag_top`

## Requirements
- R1: After reset every counter, shadow register and CPU address register is zero, so `map_addr` reads 0 and `gfx_addr` reads `{tile_code, 3'b000}`.
- R2: A write with `cpu_we` high stores `cpu_data` according to `cpu_sel`: 0 targets the horizontal scroll shadow, 1 the vertical scroll shadow (both keep only the low 9 bits), 2 the 12-bit CPU tilemap address, and 3 changes nothing.
- R3: A scroll write has no effect on the scan position until the next rising edge of `vsync_in`.
- R4: A rising edge of `vsync_in` loads the vertical counter from the vertical shadow, and loads both the horizontal counter and the active horizontal scroll from the horizontal shadow.
- R5: Each rising edge of `hsync_in` steps the vertical counter by one and reloads the horizontal counter from the active horizontal scroll; a vertical sync edge in the same cycle wins.
- R6: Each clock with `pix_en` high and no sync edge steps the horizontal counter by one.
- R7: With `flip` high both counters step by -1 instead of +1; all counter arithmetic wraps modulo 512.
- R8: With `cpu_mode` low, `map_addr` equals `{vcount[8:3], hcount[8:3]}` (row in bits 11:6, column in bits 5:0).
- R9: `gfx_addr` equals `{tile_code, vcount[2:0]}` at all times.
- R10: With `cpu_mode` high, `map_addr` equals the CPU tilemap address register, while the scan counters keep running underneath.
- R11: A sync input held high for any number of cycles produces exactly one step or load, and no sync input is used as a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_sel | input | 2 | Write target: 0 horizontal scroll, 1 vertical scroll, 2 CPU tilemap address, 3 none |
| cpu_data | input | 12 | CPU write data |
| cpu_mode | input | 1 | High hands the tilemap address outputs to the CPU address register |
| flip | input | 1 | High makes both counters count down |
| pix_en | input | 1 | Pixel clock enable for the horizontal counter |
| hsync_in | input | 1 | Asynchronous horizontal sync level |
| vsync_in | input | 1 | Asynchronous vertical sync level |
| tile_code | input | 8 | Tile code read back from the tilemap RAM |
| map_addr | output | 12 | Tilemap RAM address |
| gfx_addr | output | 11 | Graphics ROM address |

## Verification
The bench builds the block with its default parameters: 9-bit counters, 3 fine bits, 8-bit tile codes and a two-stage synchronizer. These widths are small enough for the bench to sweep sixty-four scroll pairs in both count directions and to follow every step arithmetically modulo 512. Tile column and tile row boundaries, and both wrap points, fall inside the sweep. Targeted sequences then cover writes made in mid-frame, the unused select code, data bits above the scroll width, long sync pulses, and CPU ownership of the address bus while scanning goes on.

// File: rtl/tsag_pkg.sv
package tsag_pkg;

    // Target of a CPU write.
    typedef enum logic [1:0] {
        SEL_HSCROLL = 2'd0,
        SEL_VSCROLL = 2'd1,
        SEL_MAPADDR = 2'd2,
        SEL_UNUSED  = 2'd3
    } tsag_sel_e;

    // Number of scan sync inputs handled by the edge detectors.
    localparam int NUM_SYNCS = 2;
    localparam int SYNC_H    = 0;
    localparam int SYNC_V    = 1;

endpackage

// File: rtl/tsag_edge.sv
module tsag_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], level_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // Synchronized level is high, the one a cycle older is low.
    assign rise = chain_q[LEN-2] & ~chain_q[LEN-1];
endmodule

// File: rtl/tsag_updn.sv
module tsag_updn #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = load_val;
        else if (step)
            count_d = down ? count_q - W'(1) : count_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/tsag_top.sv
module tsag_top
    import tsag_pkg::*;
#(
    parameter  int CW          = 9,
    parameter  int FINE        = 3,
    parameter  int TCW         = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int COLW        = CW - FINE,
    localparam int MAW         = 2 * COLW,
    localparam int DW          = (MAW > CW) ? MAW : CW,
    localparam int GAW         = TCW + FINE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_we,
    input  logic [1:0]     cpu_sel,
    input  logic [DW-1:0]  cpu_data,
    input  logic           cpu_mode,
    input  logic           flip,
    input  logic           pix_en,
    input  logic           hsync_in,
    input  logic           vsync_in,
    input  logic [TCW-1:0] tile_code,
    output logic [MAW-1:0] map_addr,
    output logic [GAW-1:0] gfx_addr
);
    typedef struct packed {
        logic [CW-1:0]  hshadow;
        logic [CW-1:0]  vshadow;
        logic [CW-1:0]  hactive;
        logic [MAW-1:0] cpu_addr;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_SYNCS-1:0] sync_level;
    logic [NUM_SYNCS-1:0] sync_rise;
    logic                 hs_rise, vs_rise;
    logic [CW-1:0]        hcnt, vcnt;
    tsag_sel_e            sel;

    assign sync_level = {vsync_in, hsync_in};

    for (genvar g = 0; g < NUM_SYNCS; g++) begin : g_sync
        tsag_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (sync_level[g]),
            .rise     (sync_rise[g])
        );
    end

    assign hs_rise = sync_rise[SYNC_H];
    assign vs_rise = sync_rise[SYNC_V];
    assign sel     = tsag_sel_e'(cpu_sel);

    // CPU shadow registers; the active horizontal scroll follows only at vsync.
    always_comb begin
        regs_d = regs_q;
        if (cpu_we) begin
            case (sel)
                SEL_HSCROLL: regs_d.hshadow  = cpu_data[CW-1:0];
                SEL_VSCROLL: regs_d.vshadow  = cpu_data[CW-1:0];
                SEL_MAPADDR: regs_d.cpu_addr = cpu_data[MAW-1:0];
                default:     ;
            endcase
        end
        if (vs_rise)
            regs_d.hactive = regs_q.hshadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Horizontal counter: preset at vsync, reloaded every line, stepped per pixel.
    tsag_updn #(.W(CW)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (vs_rise | hs_rise),
        .load_val (vs_rise ? regs_q.hshadow : regs_q.hactive),
        .step     (pix_en),
        .down     (flip),
        .count    (hcnt)
    );

    // Vertical counter: preset at vsync, stepped once per line.
    tsag_updn #(.W(CW)) u_vcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (vs_rise),
        .load_val (regs_q.vshadow),
        .step     (hs_rise),
        .down     (flip),
        .count    (vcnt)
    );

    assign map_addr = cpu_mode ? regs_q.cpu_addr
                               : {vcnt[CW-1:FINE], hcnt[CW-1:FINE]};
    assign gfx_addr = {tile_code, vcnt[FINE-1:0]};
endmodule

// File: rtl/tsag_chk.sv
module tsag_chk #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flip,
    input logic          pix_en,
    input logic          cpu_we,
    input logic [1:0]    cpu_sel,
    input logic          hs_rise,
    input logic          vs_rise,
    input logic [CW-1:0] vshadow,
    input logic [CW-1:0] hcnt,
    input logic [CW-1:0] vcnt
);
    assert_vload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> vcnt == $past(vshadow));

    assert_vstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_rise && !vs_rise) |=>
            vcnt == ($past(flip) ? CW'($past(vcnt) - 1) : CW'($past(vcnt) + 1)));

    assert_vhold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_rise && !vs_rise) |=> $stable(vcnt));

    assert_hhold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !hs_rise && !vs_rise) |=> $stable(hcnt));

    assert_shadow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_sel == 2'd1) |=> $stable(vshadow));

    assert_single_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> !hs_rise);
endmodule

bind tsag_top tsag_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flip    (flip),
    .pix_en  (pix_en),
    .cpu_we  (cpu_we),
    .cpu_sel (cpu_sel),
    .hs_rise (hs_rise),
    .vs_rise (vs_rise),
    .vshadow (regs_q.vshadow),
    .hcnt    (hcnt),
    .vcnt    (vcnt)
);

// File: tb/sim_tsag_top.sv
module sim_tsag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic [11:0] cpu_data = '0;
    logic        cpu_mode = 1'b0;
    logic        flip = 1'b0;
    logic        pix_en = 1'b0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic [7:0]  tile_code = 8'hA5;
    logic [11:0] map_addr;
    logic [10:0] gfx_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state, kept from the requirements.
    int m_hsh = 0, m_vsh = 0, m_hact = 0, m_hc = 0, m_vc = 0, m_caddr = 0;

    always #4 clk = ~clk;

    tsag_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_data(cpu_data), .cpu_mode(cpu_mode), .flip(flip), .pix_en(pix_en),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .tile_code(tile_code),
        .map_addr(map_addr), .gfx_addr(gfx_addr)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int wrap9(input int v);
        return ((v % 512) + 512) % 512;
    endfunction

    task automatic check_outs(input string tag);
        int exp_map;
        exp_map = cpu_mode ? m_caddr : (((m_vc >> 3) << 6) | (m_hc >> 3));
        check({tag, " map_addr"}, int'(map_addr), exp_map);
        check({tag, " gfx_addr (R9)"}, int'(gfx_addr), (int'(tile_code) << 3) | (m_vc & 7));
    endtask

    task automatic do_write(input int sel, input int data);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = 2'(sel); cpu_data = 12'(data);
        @(negedge clk);
        cpu_we = 1'b0;
        case (sel)
            0: m_hsh = data & 511;
            1: m_vsh = data & 511;
            2: m_caddr = data & 4095;
            default: ;
        endcase
    endtask

    task automatic do_vsync();
        @(negedge clk); vsync_in = 1'b1;
        repeat (3) @(negedge clk);
        vsync_in = 1'b0;
        repeat (4) @(negedge clk);
        m_vc = m_vsh; m_hc = m_hsh; m_hact = m_hsh;
    endtask

    task automatic do_hsync(input int len);
        @(negedge clk); hsync_in = 1'b1;
        repeat (len) @(negedge clk);
        hsync_in = 1'b0;
        repeat (4) @(negedge clk);
        m_vc = wrap9(m_vc + (flip ? -1 : 1));
        m_hc = m_hact;
    endtask

    task automatic do_pix(input int n);
        if (n > 0) begin
            @(negedge clk); pix_en = 1'b1;
            repeat (n - 1) @(negedge clk);
            @(negedge clk); pix_en = 1'b0;
            m_hc = wrap9(m_hc + (flip ? -n : n));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        // R1: reset state
        check_outs("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_outs("R1 after release");

        // Sweep of scroll pairs, both directions: R4 R5 R6 R7 R8 R9
        for (int f = 0; f < 2; f++) begin
            flip = f[0];
            for (int i = 0; i < 64; i++) begin
                tile_code = 8'(i * 7 + f);
                do_write(0, (i * 41 + 5) % 512);
                do_write(1, i * 8 + (i % 8));
                do_vsync();
                check_outs("R4 load");
                do_pix(i % 21);
                check_outs("R6 pixel step R7");
                do_hsync(2);
                check_outs("R5 line step R7");
                do_pix(9);
                do_hsync(1);
                check_outs("R5 second line R8");
            end
        end
        flip = 1'b0;

        // R7: wrap points
        do_write(1, 511); do_write(0, 511); do_vsync();
        do_hsync(2); check_outs("R7 vertical wrap up");
        do_pix(1); check_outs("R7 horizontal wrap up");
        flip = 1'b1;
        do_write(1, 0); do_write(0, 0); do_vsync();
        do_hsync(2); check_outs("R7 vertical wrap down");
        do_pix(1); check_outs("R7 horizontal wrap down");
        flip = 1'b0;

        // R3: mid-frame scroll writes wait for vsync
        do_write(1, 100); do_write(0, 200); do_vsync();
        do_write(1, 300); do_write(0, 40);
        check_outs("R3 write no effect");
        do_hsync(2); check_outs("R3 line uses old scroll");
        do_vsync(); check_outs("R3 new frame takes write");

        // R2: unused select, data bits above the scroll width
        do_write(3, 12'hFFF); do_vsync();
        check_outs("R2 select 3 ignored");
        do_write(0, 12'hF05); do_write(1, 12'hE3C); do_vsync();
        check_outs("R2 upper data bits dropped");

        // R10: CPU owns the address bus, scanning continues
        do_write(2, 12'hABC);
        cpu_mode = 1'b1; @(negedge clk);
        check_outs("R10 cpu address");
        do_hsync(2); do_pix(5);
        check_outs("R10 cpu address while scanning");
        cpu_mode = 1'b0; @(negedge clk);
        check_outs("R10 scan address back");

        // R11: long sync pulses give one step each
        do_hsync(25); check_outs("R11 long hsync");
        do_hsync(40); check_outs("R11 second long hsync");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule